// File: doc/BRIEF.md
# Masked Interrupt Cause Unit

This unit collects interrupt events for one group of sources, such as receive, transmit or miscellaneous events. Each of its WIDTH bits is a sticky cause flag. A one-cycle pulse on the matching `evt_i` line sets the flag. A mask decides which flags may drive the level interrupt `irq_o`. The host never writes the mask directly. It sets mask bits through one write address and clears them through another. This means concurrent agents cannot undo each other's changes by read-modify-write.

Software chooses, one bit at a time and at run time, how each cause flag is acknowledged. A flag in read-clear mode drops when the host reads it. A flag in write-clear mode drops only when the host writes a one to it. The host reaches the unit through a plain register port with write and read strobes. Read data returns on the cycle after the read strobe, qualified by `rvalid_o`.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the mask is all ones, every cause flag is zero, every clear-mode bit is zero (write-clear), and `irq_o` is low.
- R2: A one on `evt_i[i]` in a cycle sets cause bit i at that clock edge. The bit stays set until it is cleared in the way its clear-mode bit selects.
- R3: A write to address 3 (mask-set) sets every mask bit where the write data is one. Mask bits where the write data is zero keep their value.
- R4: A write to address 4 (mask-clear) clears every mask bit where the write data is one. Mask bits where the write data is zero keep their value.
- R5: A read of address 0 returns the cause flags. It clears exactly those cause bits whose clear-mode bit is 1. Bits in write-clear mode survive the read.
- R6: A write to address 0 clears cause bits where the write data is one and the clear-mode bit is 0. Bits in read-clear mode ignore such writes.
- R7: A read of address 1 returns cause AND NOT mask. It clears only bits that are unmasked and in read-clear mode. A write to address 1 clears only bits that are unmasked and in write-clear mode and have a one in the write data.
- R8: A read of address 2 returns the mask and changes no state.
- R9: If an event arrives in the same cycle as a read-clear or write-clear of that bit, the bit stays set.
- R10: `irq_o` is high exactly when some cause bit is set whose mask bit is 0. It follows register changes with no extra cycle.
- R11: Address 5 holds the clear-mode bits (1 = clear on read, 0 = write one to clear) and reads back what was written. Reads of addresses 3, 4, 6 and 7 return zero. Read data is valid, with `rvalid_o` high, for the one cycle after `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | WIDTH | One-cycle event pulses, one per cause bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | High the cycle after a read strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong cause or mask bit shows at `irq_o` in the same cycle the register takes the wrong value. The bench checks the interrupt level after every cycle it drives, so such a fault appears within one cycle of the stimulus that caused it. A missed or extra clear shows on the next read of the cause or masked-cause address. The clear-mode and mask values read back one cycle after the strobe. The scoreboard compares every read response against a model updated only from the requirements. It places the coincident event-and-clear cycles and the masked reads where a wrong clear set would change a later read.

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rvalid_o,
  output logic             irq_o
);
  localparam logic [AW-1:0] A_CAUSE = AW'(0);
  localparam logic [AW-1:0] A_MCAUS = AW'(1);
  localparam logic [AW-1:0] A_MASK  = AW'(2);
  localparam logic [AW-1:0] A_MSET  = AW'(3);
  localparam logic [AW-1:0] A_MCLR  = AW'(4);
  localparam logic [AW-1:0] A_MODE  = AW'(5);

  logic [WIDTH-1:0] cause, mask, mode;
  logic [WIDTH-1:0] live, rd_clr, wr_clr, rd_val;

  assign live = cause & ~mask;
  assign irq_o = |live;

  always_comb begin
    rd_clr = '0;
    if (rd_i && addr_i == A_CAUSE) rd_clr = cause & mode;
    if (rd_i && addr_i == A_MCAUS) rd_clr = live & mode;
  end

  always_comb begin
    wr_clr = '0;
    if (wr_i && addr_i == A_CAUSE) wr_clr = wdata_i & ~mode;
    if (wr_i && addr_i == A_MCAUS) wr_clr = wdata_i & ~mode & ~mask;
  end

  always_comb begin
    case (addr_i)
      A_CAUSE: rd_val = cause;
      A_MCAUS: rd_val = live;
      A_MASK:  rd_val = mask;
      A_MODE:  rd_val = mode;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause    <= '0;
      mask     <= '1;
      mode     <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      cause    <= (cause & ~(rd_clr | wr_clr)) | evt_i;
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_val;
      if (wr_i && addr_i == A_MSET) mask <= mask | wdata_i;
      if (wr_i && addr_i == A_MCLR) mask <= mask & ~wdata_i;
      if (wr_i && addr_i == A_MODE) mode <= wdata_i;
    end
  end

  // R2 R9
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((cause & $past(evt_i)) == $past(evt_i)));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_MSET) |=> ((mask & $past(wdata_i)) == $past(wdata_i)));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_MCLR) |=> ((mask & $past(wdata_i)) == '0));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && (addr_i == A_MSET || addr_i == A_MCLR)) |=> $stable(mask));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !wr_i) |=> ((cause & $past(cause)) == $past(cause)));

  // R10
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_o);

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rvalid_o);
endmodule

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb;
  localparam int W = 32;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] evt_i = '0, wdata_i = '0;
  logic wr_i = 0, rd_i = 0;
  logic [2:0] addr_i = '0;
  logic [W-1:0] rdata_o;
  logic rvalid_o, irq_o;
  int checks = 0, errors = 0;
  logic [W-1:0] m_cause = '0, m_mask = '1, m_mode = '0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  irq_cause_unit #(.WIDTH(W), .AW(3)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rvalid_o) begin
    if (exp_q.size() == 0) chk("R11 unexpected", rdata_o, '0);
    else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
  end

  task automatic cyc(bit rd, bit wr, logic [2:0] a, logic [W-1:0] wd,
                     logic [W-1:0] ev, string tag);
    logic [W-1:0] live, rv, clr;
    @(negedge clk);
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = wd; evt_i = ev;
    live = m_cause & ~m_mask;
    rv = (a == 0) ? m_cause : (a == 1) ? live : (a == 2) ? m_mask :
         (a == 5) ? m_mode : '0;
    clr = '0;
    if (rd && a == 0) clr |= m_cause & m_mode;
    if (rd && a == 1) clr |= live & m_mode;
    if (wr && a == 0) clr |= wd & ~m_mode;
    if (wr && a == 1) clr |= wd & ~m_mode & ~m_mask;
    if (rd) begin exp_q.push_back(rv); tag_q.push_back(tag); end
    @(posedge clk); #1;
    rd_i = 0; wr_i = 0; evt_i = '0;
    m_cause = (m_cause & ~clr) | ev;
    if (wr && a == 3) m_mask |= wd;
    if (wr && a == 4) m_mask &= ~wd;
    if (wr && a == 5) m_mode = wd;
    @(negedge clk);
    chk("R10 irq", {31'd0, irq_o}, {31'd0, |(m_cause & ~m_mask)});
  endtask

  task automatic rd(logic [2:0] a, string tag); cyc(1, 0, a, '0, '0, tag); endtask
  task automatic wr(logic [2:0] a, logic [W-1:0] d); cyc(0, 1, a, d, '0, "wr"); endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq_o}, '0);
    rd(2, "R1 mask");
    rd(0, "R1 cause");
    rd(5, "R1 mode");
    cyc(0, 0, 0, '0, 32'h0000_0011, "R2 evt");
    rd(0, "R2 sticky");
    rd(0, "R5 wc survives read");
    wr(4, 32'h0000_0001);
    rd(2, "R4 mask clear");
    rd(1, "R7 masked view");
    wr(3, 32'h0000_0001);
    rd(2, "R3 mask set");
    wr(4, 32'hFFFF_0000);
    rd(2, "R4 partial");
    wr(3, 32'hFFFF_FFFF);
    rd(2, "R3 all ones");
    wr(0, 32'h0000_0010);
    rd(0, "R6 w1c");
    wr(5, 32'h0000_00F0);
    rd(5, "R11 mode readback");
    cyc(0, 0, 0, '0, 32'h0000_00A5, "evt");
    rd(0, "R5 read clear");
    rd(0, "R5 after read");
    wr(0, 32'h0000_00FF);
    rd(0, "R6 rc ignores write");
    cyc(0, 0, 0, '0, 32'h0000_00C3, "evt");
    wr(4, 32'h0000_0041);
    rd(1, "R7 masked read");
    rd(0, "R7 masked bits kept");
    wr(1, 32'h0000_00FF);
    rd(0, "R7 masked write");
    rd(2, "R8 mask no effect");
    rd(2, "R8 mask again");
    cyc(0, 0, 0, '0, 32'h0000_0030, "evt");
    cyc(1, 0, 0, '0, 32'h0000_0020, "R9 event vs read clear");
    rd(0, "R9 survived read");
    cyc(0, 1, 0, 32'h0000_0082, 32'h0000_0002, "R9 event vs write");
    rd(0, "R9 survived write");
    rd(3, "R11 wo reads zero");
    rd(4, "R11 wo reads zero");
    rd(7, "R11 unused zero");
    wr(3, 32'hFFFF_FFFF);
    rd(1, "R10 masked out");
    repeat (3) @(negedge clk);
    chk("R11 queue drained", 32'(exp_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule